// File: doc/BRIEF.md
# TMDS Three-Channel Video Encoder with Serializer Model

This block turns a stream of RGB pixels into the four serial lanes of a TMDS video link. It accepts one pixel every ten cycles of its bit-rate clock. A pixel is an 8-bit red, green and blue value, a data-enable, and horizontal and vertical sync. The block produces one 10-bit symbol per colour channel. While data-enable is high, each byte passes through a transition-minimising stage and then a DC-balancing stage, which tracks a signed running disparity for that channel. While data-enable is low, each channel sends one of four fixed control symbols. Only the blue channel carries the two sync bits. Green and red always send the all-zero control code.

A 10:1 shift-register model serialises the three symbols onto data lanes 0 (blue), 1 (green) and 2 (red). A fourth lane carries the clock pattern. The block runs from a single bit-rate clock. An internal divide-by-ten counter marks the pixel boundary on `pix_tick`, and the pixel source presents its next pixel in that cycle.

Top module: `tmds_video_tx`

## Requirements
- R1: While `rst` is high, all three symbol outputs hold 1101010100, the lanes `tx_data` and `tx_clk` are 0, and `pix_tick` is 0.
- R2: `pix_tick` is high for exactly one cycle in every ten. The pixel inputs are sampled at the clock edge that ends a `pix_tick` cycle, and the symbol outputs change only at that edge.
- R3: With data-enable high, decoding the symbol recovers the byte. Decoding works as follows: if bit 9 is set, invert bits 7:0 to give t. Then d0 = t0, and for i ≥ 1, di = ti XOR ti-1 when bit 8 is 1, or the XNOR of the same two bits when bit 8 is 0.
- R4: For a data symbol, bit 8 is 0 exactly when the byte holds more than four ones, or exactly four ones with bit 0 clear. Otherwise bit 8 is 1.
- R5: With data-enable low, the blue symbol for control pair {C1,C0} is: 00 gives 1101010100, 01 gives 0010101011, 10 gives 0101010100, 11 gives 1010101011. The colour inputs have no effect on it.
- R6: On the blue channel, C0 is `hsync` and C1 is `vsync`. During blanking, green and red always send the code for 00, whatever the sync and colour inputs.
- R7: Running disparity is the sum over a channel's symbols of (ones − zeros). It returns to 0 on every control symbol and never exceeds 10 in magnitude. After a blanking pixel, the blue byte 0x00 encodes as 0100000000, and a second 0x00 right after it encodes as 1111111111.
- R8: A symbol captured at edge E is sent on its lane least significant bit first. Bit k is present during the cycle that follows edge E+1+k. The serial word equals the parallel symbol output.
- R9: `tx_clk` carries five ones followed by five zeros in each ten-bit word, aligned with the data lane words. As a 10-bit word with bit 0 sent first, this is 0000011111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, ten cycles per pixel |
| rst | input | 1 | Synchronous active-high reset |
| de | input | 1 | Data enable: high for active video |
| hsync | input | 1 | Horizontal sync, sent as blue C0 |
| vsync | input | 1 | Vertical sync, sent as blue C1 |
| red | input | 8 | Red component |
| green | input | 8 | Green component |
| blue | input | 8 | Blue component |
| pix_tick | output | 1 | High in the cycle where the pixel is sampled |
| sym_blue | output | 10 | Current blue symbol |
| sym_green | output | 10 | Current green symbol |
| sym_red | output | 10 | Current red symbol |
| tx_data | output | 3 | Serial data lanes: bit 0 blue, bit 1 green, bit 2 red |
| tx_clk | output | 1 | Serial clock-pattern lane |

## Verification
A running disparity corrupted on one channel does not show up in the current symbol. It shows in the next data symbol's choice of bit 9, and later in a stream disparity that walks past 10. It is cleared again by the next control symbol. The pair of 0x00 pixels after blanking therefore exposes such a fault within two pixels. A slip in the divide-by-ten phase shifts each lane word by whole bits. That fault is caught on the very next word, because the clock lane stops reading 0000011111 and the serial words stop matching the parallel symbols. A fault in the stage-1 choice of XOR or XNOR appears at once as a wrong recovered byte or a wrong bit 8.

// File: rtl/tmds_pkg.sv
`timescale 1ns/1ps
package tmds_pkg;
  localparam int BYTE_W   = 8;
  localparam int SYM_W    = 10;
  localparam int DISP_W   = 6;
  localparam int DISP_MAX = 10;
  localparam int N_CH     = 3;
  localparam int N_LANE   = N_CH + 1;

  typedef logic [BYTE_W-1:0]        byte_t;
  typedef logic [BYTE_W:0]          qm_t;
  typedef logic [SYM_W-1:0]         sym_t;
  typedef logic signed [DISP_W-1:0] disp_t;

  typedef struct packed {
    sym_t  sym;
    disp_t disp;
  } enc_t;

  localparam sym_t CTL_00 = 10'b1101010100;
  localparam sym_t CTL_01 = 10'b0010101011;
  localparam sym_t CTL_10 = 10'b0101010100;
  localparam sym_t CTL_11 = 10'b1010101011;

  // Lower half ones: sent first, so the lane shows five highs then five lows.
  localparam sym_t CLK_WORD = sym_t'((1 << (SYM_W / 2)) - 1);

  function automatic int f_ones(input byte_t v);
    int n;
    n = 0;
    for (int i = 0; i < BYTE_W; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic logic f_use_xnor(input byte_t d);
    int n;
    n = f_ones(d);
    return (n > BYTE_W / 2) || ((n == BYTE_W / 2) && !d[0]);
  endfunction

  function automatic qm_t f_stage1(input byte_t d);
    qm_t  q;
    logic x;
    x    = f_use_xnor(d);
    q    = '0;
    q[0] = d[0];
    for (int i = 1; i < BYTE_W; i++)
      q[i] = x ? ~(q[i-1] ^ d[i]) : (q[i-1] ^ d[i]);
    q[BYTE_W] = ~x;
    return q;
  endfunction

  function automatic enc_t f_stage2(input qm_t qm, input disp_t disp);
    enc_t  r;
    int    n1, n0, c, nc;
    byte_t low;
    logic  b8;
    low = qm[BYTE_W-1:0];
    b8  = qm[BYTE_W];
    n1  = f_ones(low);
    n0  = BYTE_W - n1;
    c   = int'(disp);
    if (c == 0 || n1 == n0) begin
      r.sym = {~b8, b8, (b8 ? low : ~low)};
      nc    = b8 ? (c + n1 - n0) : (c + n0 - n1);
    end else if ((c > 0 && n1 > n0) || (c < 0 && n0 > n1)) begin
      r.sym = {1'b1, b8, ~low};
      nc    = c + (b8 ? 2 : 0) + n0 - n1;
    end else begin
      r.sym = {1'b0, b8, low};
      nc    = c - (b8 ? 0 : 2) + n1 - n0;
    end
    r.disp = disp_t'(nc);
    return r;
  endfunction

  function automatic sym_t f_ctrl(input logic [1:0] c);
    case (c)
      2'b00:   return CTL_00;
      2'b01:   return CTL_01;
      2'b10:   return CTL_10;
      default: return CTL_11;
    endcase
  endfunction

  function automatic logic f_is_ctrl(input sym_t s);
    return (s == CTL_00) || (s == CTL_01) || (s == CTL_10) || (s == CTL_11);
  endfunction
endpackage

// File: rtl/tmds_pix_timer.sv
`timescale 1ns/1ps
module tmds_pix_timer #(
  parameter int RATIO = 10
) (
  input  logic clk,
  input  logic rst,
  output logic tick,
  output logic load
);
  localparam int PW = $clog2(RATIO);
  localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst)                phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                    phase <= phase + 1'b1;
  end

  assign tick = (phase == LAST);
  assign load = (phase == '0);

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  // R8
  load_follows_tick_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> load);

  // R2
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    phase <= LAST);
endmodule

// File: rtl/tmds_chan_enc.sv
`timescale 1ns/1ps
module tmds_chan_enc
  import tmds_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ce,
  input  logic       de,
  input  byte_t      din,
  input  logic [1:0] ctl,
  output sym_t       sym
);
  disp_t disp;
  qm_t   stage1_word;
  enc_t  stage2_out;
  sym_t  ctl_sym;
  logic  ld_data;
  logic  ld_ctrl;

  assign stage1_word = f_stage1(din);
  assign stage2_out  = f_stage2(stage1_word, disp);
  assign ctl_sym     = f_ctrl(ctl);
  assign ld_data     = ce && de;
  assign ld_ctrl     = ce && !de;

  always_ff @(posedge clk) begin
    if (rst) begin
      sym  <= CTL_00;
      disp <= '0;
    end else if (ld_data) begin
      sym  <= stage2_out.sym;
      disp <= stage2_out.disp;
    end else if (ld_ctrl) begin
      sym  <= ctl_sym;
      disp <= '0;
    end
  end

  // R7
  disp_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (disp <= DISP_MAX) && (disp >= -DISP_MAX));

  // R7
  ctl_clears_disp_chk: assert property (@(posedge clk) disable iff (rst)
    ld_ctrl |=> (disp == 0));

  // R5
  ctl_code_chk: assert property (@(posedge clk) disable iff (rst)
    ld_ctrl |=> f_is_ctrl(sym));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(sym) && $stable(disp)));

  // R4
  data_bit8_chk: assert property (@(posedge clk) disable iff (rst)
    ld_data |=> (sym[BYTE_W] == $past(stage1_word[BYTE_W])));
endmodule

// File: rtl/tmds_lane_ser.sv
`timescale 1ns/1ps
module tmds_lane_ser
  import tmds_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  sym_t word,
  output logic ser
);
  sym_t shreg;

  always_ff @(posedge clk) begin
    if (rst)       shreg <= '0;
    else if (load) shreg <= word;
    else           shreg <= shreg >> 1;
  end

  assign ser = shreg[0];

  // R8
  lsb_first_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (ser == $past(word[0])));
endmodule

// File: rtl/tmds_video_tx.sv
`timescale 1ns/1ps
module tmds_video_tx
  import tmds_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              de,
  input  logic              hsync,
  input  logic              vsync,
  input  logic [BYTE_W-1:0] red,
  input  logic [BYTE_W-1:0] green,
  input  logic [BYTE_W-1:0] blue,
  output logic              pix_tick,
  output logic [SYM_W-1:0]  sym_blue,
  output logic [SYM_W-1:0]  sym_green,
  output logic [SYM_W-1:0]  sym_red,
  output logic [N_CH-1:0]   tx_data,
  output logic              tx_clk
);
  logic       ser_load;
  byte_t      ch_din  [N_CH];
  logic [1:0] ch_ctl  [N_CH];
  sym_t       ch_sym  [N_CH];
  sym_t       lane_word [N_LANE];
  logic       lane_bit  [N_LANE];

  tmds_pix_timer #(.RATIO(SYM_W)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .tick (pix_tick),
    .load (ser_load)
  );

  // Channel 0 blue, 1 green, 2 red; sync rides only on blue.
  assign ch_din[0] = blue;
  assign ch_din[1] = green;
  assign ch_din[2] = red;
  assign ch_ctl[0] = {vsync, hsync};

  generate
    for (genvar c = 1; c < N_CH; c++) begin : g_quiet_ctl
      assign ch_ctl[c] = 2'b00;
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_enc
      tmds_chan_enc u_enc (
        .clk (clk),
        .rst (rst),
        .ce  (pix_tick),
        .de  (de),
        .din (ch_din[c]),
        .ctl (ch_ctl[c]),
        .sym (ch_sym[c])
      );
    end

    for (genvar l = 0; l < N_LANE; l++) begin : g_lane
      if (l < N_CH) begin : g_data
        assign lane_word[l] = ch_sym[l];
        assign tx_data[l]   = lane_bit[l];
      end else begin : g_clock
        assign lane_word[l] = CLK_WORD;
        assign tx_clk       = lane_bit[l];
      end
      tmds_lane_ser u_ser (
        .clk  (clk),
        .rst  (rst),
        .load (ser_load),
        .word (lane_word[l]),
        .ser  (lane_bit[l])
      );
    end
  endgenerate

  assign sym_blue  = ch_sym[0];
  assign sym_green = ch_sym[1];
  assign sym_red   = ch_sym[2];

  // R6
  quiet_channels_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_tick && !de) |=> ((sym_green == CTL_00) && (sym_red == CTL_00)));

  // R9
  clk_lane_high_chk: assert property (@(posedge clk) disable iff (rst)
    ser_load |=> tx_clk);
endmodule

// File: tb/tmds_video_tx_tb.sv
`timescale 1ns/1ps
module tmds_video_tx_tb;
  import tmds_pkg::*;

  typedef struct {
    logic  de, hs, vs;
    byte_t r, g, b;
    int    want_b;
  } pix_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        de = 1'b0, hsync = 1'b0, vsync = 1'b0;
  byte_t       red = '0, green = '0, blue = '0;
  logic        pix_tick;
  sym_t        sym_blue, sym_green, sym_red;
  logic [2:0]  tx_data;
  logic        tx_clk;

  pix_t stim_q[$];
  pix_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  int   bdisp[3] = '{0, 0, 0};

  always #2 clk = ~clk;

  tmds_video_tx u_dut (
    .clk(clk), .rst(rst), .de(de), .hsync(hsync), .vsync(vsync),
    .red(red), .green(green), .blue(blue), .pix_tick(pix_tick),
    .sym_blue(sym_blue), .sym_green(sym_green), .sym_red(sym_red),
    .tx_data(tx_data), .tx_clk(tx_clk)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Driver: queue a pixel; the feeder applies it at the next pixel slot.
  task automatic send(input logic d, input logic h, input logic v,
                      input byte_t r, input byte_t g, input byte_t b,
                      input int want_b = -1);
    pix_t p;
    p.de = d; p.hs = h; p.vs = v; p.r = r; p.g = g; p.b = b; p.want_b = want_b;
    stim_q.push_back(p);
  endtask

  function automatic byte_t dec_data(input sym_t w);
    byte_t t, b;
    t    = w[9] ? ~w[7:0] : w[7:0];
    b[0] = t[0];
    for (int i = 1; i < 8; i++) b[i] = w[8] ? (t[i] ^ t[i-1]) : ~(t[i] ^ t[i-1]);
    return b;
  endfunction

  function automatic int dec_ctl(input sym_t w);
    case (w)
      10'b1101010100: return 0;
      10'b0010101011: return 1;
      10'b0101010100: return 2;
      10'b1010101011: return 3;
      default:        return -1;
    endcase
  endfunction

  task automatic score(input sym_t w[4], input sym_t par[3]);
    pix_t  e;
    byte_t eb;
    int    ec, n1, dv;
    logic  exp8;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R8", "serial word with no pixel", 0, 1);
      return;
    end
    e = exp_q.pop_front();
    chk(w[3] == 10'h01F, "R9", "clock lane word", int'(w[3]), 10'h01F);
    for (int ch = 0; ch < 3; ch++) begin
      chk(w[ch] == par[ch], "R8", "serial word vs parallel symbol",
          int'(w[ch]), int'(par[ch]));
      eb = (ch == 0) ? e.b : (ch == 1) ? e.g : e.r;
      ec = (ch == 0) ? int'({e.vs, e.hs}) : 0;
      if (e.de) begin
        chk(dec_data(w[ch]) == eb, "R3", "decoded byte", int'(dec_data(w[ch])), int'(eb));
        n1   = $countones(eb);
        exp8 = !((n1 > 4) || (n1 == 4 && !eb[0]));
        chk(w[ch][8] == exp8, "R4", "stage-1 mode bit", int'(w[ch][8]), int'(exp8));
        bdisp[ch] += 2 * $countones(w[ch]) - 10;
        dv = bdisp[ch];
        chk(dv <= 10 && dv >= -10, "R7", "stream disparity bound", dv, 10);
      end else begin
        chk(dec_ctl(w[ch]) == ec, (ch == 0) ? "R5" : "R6", "control code",
            dec_ctl(w[ch]), ec);
        bdisp[ch] = 0;
      end
    end
    if (e.want_b >= 0)
      chk(int'(w[0]) == e.want_b, "R7", "blue symbol after blanking", int'(w[0]), e.want_b);
  endtask

  // Feeder: one pixel per slot, blank filler when no stimulus waits.
  initial begin
    pix_t p;
    wait (rst == 1'b0);
    forever begin
      @(negedge clk);
      if (!pix_tick) continue;
      if (stim_q.size() != 0) p = stim_q.pop_front();
      else begin
        p.de = 0; p.hs = 0; p.vs = 0; p.r = 8'h00; p.g = 8'h00; p.b = 8'h00; p.want_b = -1;
      end
      de = p.de; hsync = p.hs; vsync = p.vs; red = p.r; green = p.g; blue = p.b;
      exp_q.push_back(p);
    end
  end

  // Monitor: rebuild lane words bit by bit and score each completed word.
  initial begin
    int   idx;
    bit   seen;
    sym_t acc[4];
    sym_t par[3];
    idx = -1; seen = 0;
    acc = '{default: '0};
    par = '{default: '0};
    forever begin
      @(negedge clk);
      if (rst) begin idx = -1; continue; end
      if (pix_tick) idx = 8;
      if (idx >= 0) begin
        acc[0][idx] = tx_data[0];
        acc[1][idx] = tx_data[1];
        acc[2][idx] = tx_data[2];
        acc[3][idx] = tx_clk;
        if (idx == 9) begin
          if (seen) score(acc, par);
          par[0] = sym_blue; par[1] = sym_green; par[2] = sym_red;
          seen = 1;
          idx  = 0;
        end else idx++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R2", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [15:0] lf;
    byte_t       sp[14];
    int          tick_seen;
    sp = '{8'h00, 8'hFF, 8'h0F, 8'h1E, 8'hF0, 8'hE1, 8'h55,
           8'hAA, 8'h01, 8'h80, 8'h7F, 8'hFE, 8'h10, 8'hEF};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(sym_blue == 10'b1101010100, "R1", "blue symbol in reset", int'(sym_blue), 10'h354);
    chk(sym_green == 10'b1101010100, "R1", "green symbol in reset", int'(sym_green), 10'h354);
    chk(sym_red == 10'b1101010100, "R1", "red symbol in reset", int'(sym_red), 10'h354);
    chk(tx_data == 3'b000 && tx_clk == 1'b0, "R1", "lanes in reset",
        int'({tx_clk, tx_data}), 0);
    chk(pix_tick == 1'b0, "R1", "pix_tick in reset", int'(pix_tick), 0);
    rst = 1'b0;

    // R2: one tick in every ten cycles
    tick_seen = 0;
    repeat (40) begin
      @(negedge clk);
      if (pix_tick) tick_seen++;
    end
    chk(tick_seen == 4, "R2", "ticks in 40 cycles", tick_seen, 4);

    // R5/R6: control pairs with colour inputs that must be ignored
    send(0, 0, 0, 8'h12, 8'h34, 8'h56);
    send(0, 1, 0, 8'hFF, 8'h00, 8'hA5);
    send(0, 0, 1, 8'h3C, 8'hC3, 8'h0F);
    send(0, 1, 1, 8'h81, 8'h7E, 8'hFF);
    // R7: disparity cleared by blanking; sync ignored during active video
    send(0, 0, 0, 8'h00, 8'h00, 8'h00);
    send(1, 0, 0, 8'h20, 8'h40, 8'h00, 10'h100);
    send(1, 1, 1, 8'h21, 8'h41, 8'h00, 10'h3FF);
    // R3/R4: bytes at the ones-count boundaries
    foreach (sp[i]) send(1, i[0], i[1], {sp[i][3:0], sp[i][7:4]}, ~sp[i], sp[i]);
    send(0, 1, 0, 8'h99, 8'h99, 8'h99);
    // Mixed run with periodic blanking
    lf = 16'hACE1;
    for (int i = 0; i < 160; i++) begin
      byte_t r, g, b;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]}; r = lf[7:0];
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]}; g = lf[15:8];
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]}; b = lf[11:4];
      send((i % 40) < 32, lf[0], lf[1], r, g, b);
    end
    while (stim_q.size() != 0) @(posedge clk);
    repeat (40) @(posedge clk);
    finish_run();
  end
endmodule